// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block moves single-word register writes from a fast bus clock into a slow, always-running clock domain of a few tens of kilohertz. A bus write is latched into holding registers on the bus side. A request toggle then crosses into the slow domain. After a fixed number of slow-clock edges the word is committed into a small register bank. An acknowledge toggle returns to the bus side, and that return ends the transaction.

Software sees the transaction through a status word. The word has a busy flag, a ready-for-next flag, a sticky completion flag that a status-read strobe clears, and a sticky error flag. The error flag is set when a second write arrives while one is still in flight. An interrupt-enable register on the bus side is written at once, without the synchronizer. It selects which flags drive the interrupt line. The committed bank can be read back through a port clocked by the slow clock.

Top module: `slow_wr_sync`

## Requirements
- R1: A write to any address other than the enable address (6), made while not busy, is accepted. After that bus edge, status bit 10 (busy) is 1 and bit 9 (ready for next) is 0.
- R2: An accepted word is stored at its address in the slow bank no earlier than the fourth slow-clock edge after acceptance. When the acknowledge returns, bit 8 (complete) is set and bit 10 is cleared.
- R3: A status-read strobe clears bit 8 at the next bus edge, provided no completion arrives in that same cycle.
- R4: A write to a non-enable address made while busy sets bit 7 (error) at the next bus edge. The word is discarded, so the bank keeps its previous contents.
- R5: A write to the status address (5) with data bit 7 set clears bit 7 only when that write completes. Until then bit 7 stays set.
- R6: A write to the enable address takes effect at the next bus edge. Data bits 9, 8 and 7 enable the ready-for-next, complete and error flags. The write never sets busy, complete or error, even while another write is in flight.
- R7: The interrupt output is registered. It equals the OR of (bit 9 AND enable 9), (bit 8 AND enable 8) and (bit 7 AND enable 7), taken one bus cycle earlier.
- R8: After reset the status word is 0x0000_0200, the interrupt output is 0 and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Fast bus clock |
| clk_slow | input | 1 | Slow always-on clock |
| rst | input | 1 | Synchronous active-high reset, held across several slow edges |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write word address |
| wr_data | input | DATA_W | Bus write data |
| stat_rd | input | 1 | Status-read strobe, clears the complete flag |
| rd_addr | input | ADDR_W | Slow-bank read address (slow domain) |
| rd_data | output | DATA_W | Slow-bank read data, registered on clk_slow |
| status | output | DATA_W | Status word: bit 10 busy, 9 ready, 8 complete, 7 error |
| irq | output | 1 | Registered interrupt request |

## Verification
Every bank address other than the status and enable addresses is written with a distinct value that the bench computes arithmetically. For each write the bench reads the value back and counts the slow edges from acceptance to completion, which separates a wrong address decode from a commit that happens too early. One write in the sweep is overlapped with an enable write, showing that the bypass path raises neither busy nor error. A deliberate overlap of two bank writes shows that the second word is dropped and error is set. All eight enable patterns are then swept against two flag states, with and without complete set, which separates each flag's gate in the interrupt. Last, an error-clearing status write shows that the error flag only falls when that write finishes.

// File: rtl/slow_wr_sync_pkg.sv
package slow_wr_sync_pkg;

  localparam int BUSY_BIT = 10;
  localparam int NEXT_BIT = 9;
  localparam int DONE_BIT = 8;
  localparam int ERR_BIT  = 7;

  typedef struct packed {
    logic nxt;
    logic cmp;
    logic err;
  } ien_t;

endpackage

// File: rtl/wsync_tgl_sync.sv
module wsync_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);

  logic [STAGES-1:0] chain;
  logic              seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      seen  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], tgl_in};
      seen  <= chain[STAGES-1];
    end
  end

  // one-cycle level whenever the synchronized toggle changes
  assign pulse = chain[STAGES-1] ^ seen;

endmodule

// File: rtl/wsync_bus_side.sv
module wsync_bus_side
  import slow_wr_sync_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int STAT_IDX = 5,
  parameter int IEN_IDX  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  input  logic              ack_pulse,
  output logic              req_tgl,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] IEN_A  = ADDR_W'(IEN_IDX);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_IDX);

  ien_t ien;
  logic is_ien;
  logic accept;
  logic collide;
  logic err_clr;

  assign is_ien  = (wr_addr == IEN_A);
  assign accept  = wr_en && !is_ien && !busy;
  assign collide = wr_en && !is_ien && busy;
  assign err_clr = ack_pulse && (hold_addr == STAT_A) && hold_data[ERR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl   <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      ien       <= '0;
      irq       <= 1'b0;
    end else begin
      if (accept) begin
        hold_addr <= wr_addr;
        hold_data <= wr_data;
        req_tgl   <= ~req_tgl;
      end

      if (accept)         busy <= 1'b1;
      else if (ack_pulse) busy <= 1'b0;

      // completion wins over a concurrent status read
      if (ack_pulse)    done <= 1'b1;
      else if (stat_rd) done <= 1'b0;

      // a new collision wins over a clearing completion
      if (collide)      err <= 1'b1;
      else if (err_clr) err <= 1'b0;

      if (wr_en && is_ien)
        ien <= '{nxt: wr_data[NEXT_BIT], cmp: wr_data[DONE_BIT], err: wr_data[ERR_BIT]};

      irq <= (!busy && ien.nxt) || (done && ien.cmp) || (err && ien.err);
    end
  end

endmodule

// File: rtl/wsync_slow_bank.sv
module wsync_slow_bank #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int SLOW_LAT = 4
) (
  input  logic              clk_slow,
  input  logic              rst,
  input  logic              req_tgl,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack_tgl
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int STAGES = SLOW_LAT - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              commit;

  // request seen after STAGES edges, committed on the following edge
  wsync_tgl_sync #(.STAGES(STAGES)) u_req_sync (
    .clk    (clk_slow),
    .rst    (rst),
    .tgl_in (req_tgl),
    .pulse  (commit)
  );

  // bank without reset so it maps onto block RAM
  always_ff @(posedge clk_slow) begin
    if (commit) mem[hold_addr] <= hold_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk_slow) begin
    if (rst)         ack_tgl <= 1'b0;
    else if (commit) ack_tgl <= ~ack_tgl;
  end

endmodule

// File: rtl/slow_wr_sync.sv
module slow_wr_sync
  import slow_wr_sync_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int STAT_IDX  = 5,
  parameter int IEN_IDX   = 6,
  parameter int SLOW_LAT  = 4,
  parameter int FAST_SYNC = 2
) (
  input  logic              clk_bus,
  input  logic              clk_slow,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] status,
  output logic              irq
);

  logic              req_tgl;
  logic              ack_tgl;
  logic              ack_pulse;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic              done;
  logic              err;

  wsync_bus_side #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STAT_IDX (STAT_IDX),
    .IEN_IDX  (IEN_IDX)
  ) u_bus (
    .clk       (clk_bus),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .stat_rd   (stat_rd),
    .ack_pulse (ack_pulse),
    .req_tgl   (req_tgl),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .irq       (irq)
  );

  wsync_slow_bank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SLOW_LAT (SLOW_LAT)
  ) u_slow (
    .clk_slow  (clk_slow),
    .rst       (rst),
    .req_tgl   (req_tgl),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .ack_tgl   (ack_tgl)
  );

  wsync_tgl_sync #(.STAGES(FAST_SYNC)) u_ack_sync (
    .clk    (clk_bus),
    .rst    (rst),
    .tgl_in (ack_tgl),
    .pulse  (ack_pulse)
  );

  always_comb begin
    status           = '0;
    status[BUSY_BIT] = busy;
    status[NEXT_BIT] = !busy;
    status[DONE_BIT] = done;
    status[ERR_BIT]  = err;
  end

endmodule

// File: rtl/slow_wr_sync_chk.sv
module slow_wr_sync_chk #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int IEN_IDX = 6
) (
  input logic              clk_bus,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              stat_rd,
  input logic [DATA_W-1:0] status
);

  localparam logic [ADDR_W-1:0] IEN_A = ADDR_W'(IEN_IDX);

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk_bus) disable iff (rst)
    (wr_en && wr_addr != IEN_A && !status[10]) |=> (status[10] && !status[9])); // R1

  AST_DONE_ON_RETIRE: assert property (@(posedge clk_bus) disable iff (rst)
    $rose(status[8]) |-> $fell(status[10])); // R2

  AST_READ_CLEARS_DONE: assert property (@(posedge clk_bus) disable iff (rst)
    (stat_rd && !status[10]) |=> !status[8]); // R3

  AST_COLLIDE_SETS_ERR: assert property (@(posedge clk_bus) disable iff (rst)
    (wr_en && wr_addr != IEN_A && status[10]) |=> status[7]); // R4

  AST_ERR_CLEARS_ON_RETIRE: assert property (@(posedge clk_bus) disable iff (rst)
    $fell(status[7]) |-> $fell(status[10])); // R5

  AST_IEN_NO_BUSY: assert property (@(posedge clk_bus) disable iff (rst)
    (wr_en && wr_addr == IEN_A && !status[10]) |=> !status[10]); // R6

endmodule

bind slow_wr_sync slow_wr_sync_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .IEN_IDX (IEN_IDX)
) u_chk (
  .clk_bus (clk_bus),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .stat_rd (stat_rd),
  .status  (status)
);

// File: tb/slow_wr_sync_bench.sv
module slow_wr_sync_bench;

  localparam int AW   = 4;
  localparam int DW   = 32;
  localparam int STAT = 5;
  localparam int IEN  = 6;

  logic          clk = 1'b0;
  logic          clk_slow = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          stat_rd = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] status;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  int scnt = 0;
  int s0 = 0;

  always #5 clk = ~clk;
  always #65 clk_slow = ~clk_slow;
  always @(posedge clk_slow) scnt <= scnt + 1;

  slow_wr_sync u_slow_wr_sync (
    .clk_bus  (clk),
    .clk_slow (clk_slow),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .stat_rd  (stat_rd),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .status   (status),
    .irq      (irq)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return 32'h9E37_79B9 * (a + 1) ^ 32'h0F0F_0000;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    s0 = scnt;
  endtask

  task automatic stat_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k;
    k = 0;
    while (status[8] !== 1'b1 && k < 2000) begin
      tick();
      k++;
    end
    check(req, {31'b0, status[8]}, 32'd1);
  endtask

  task automatic bank_read(input int a, output logic [DW-1:0] v);
    @(negedge clk_slow); rd_addr = AW'(a);
    @(posedge clk_slow);
    @(negedge clk_slow); v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (40) tick();
    rst = 1'b0;
    tick();
    // R8 reset state
    check("R8 status", status, 32'h0000_0200);
    check("R8 irq", {31'b0, irq}, 32'd0);

    // sweep all bank addresses (R1, R2), one overlapped enable write (R6)
    for (int a = 0; a < 16; a++) begin
      if (a == STAT || a == IEN) continue;
      stat_read();
      bus_write(a, pat(a));
      check("R1 busy/next", status & 32'h600, 32'h400);
      if (a == 3) begin
        bus_write(IEN, 32'h0);
        check("R6 no error while busy", {31'b0, status[7]}, 32'd0);
        check("R6 busy kept", {31'b0, status[10]}, 32'd1);
      end
      wait_done("R2 done");
      check("R2 retired word", status, 32'h0000_0300);
      check("R2 latency >= 4 slow edges", {31'b0, (scnt - s0) >= 4}, 32'd1);
      bank_read(a, v);
      check("R2 bank data", v, pat(a));
    end

    // R4 collision
    stat_read();
    bus_write(2, 32'h1234_5678);
    bus_write(3, 32'hDEAD_BEEF);
    check("R4 error set", {31'b0, status[7]}, 32'd1);
    wait_done("R4 first write retires");
    bank_read(3, v);
    check("R4 dropped word", v, pat(3));
    bank_read(2, v);
    check("R4 kept word", v, 32'h1234_5678);

    // R7 sweep, state: next=1 done=1 err=1
    for (int e = 0; e < 8; e++) begin
      bus_write(IEN, DW'(e) << 7);
      tick();
      check("R7 irq all flags", {31'b0, irq}, {31'b0, e != 0});
    end
    // R3 status read clears complete
    stat_read();
    check("R3 done cleared", {31'b0, status[8]}, 32'd0);
    check("R6 enable write left done clear", status & 32'h780, 32'h280);
    // R7 sweep, state: next=1 done=0 err=1
    for (int e = 0; e < 8; e++) begin
      bus_write(IEN, DW'(e) << 7);
      tick();
      check("R7 irq no done", {31'b0, irq}, {31'b0, (e & 5) != 0});
    end
    bus_write(IEN, 32'h0);
    tick();
    check("R7 irq masked", {31'b0, irq}, 32'd0);

    // R5 clearing the error goes through the synchronizer
    bus_write(STAT, 32'h0000_0080);
    check("R5 error held while busy", {31'b0, status[7]}, 32'd1);
    wait_done("R5 clear write retires");
    check("R5 error cleared", {31'b0, status[7]}, 32'd0);
    check("R5 final status", status, 32'h0000_0300);

    finish_up();
  end

endmodule